// File: doc/BRIEF.md
# Strided Gapped Block Copy Engine

This block copies bytes from one memory region to another. Each side has its own shape: a run of contiguous bytes, then a skipped gap, repeated. The source and destination shapes are independent, so a copy can pack a gapped source into a dense destination, spread a dense source out, or change the stride between the two. Software writes the base addresses, the total byte count and the two shapes into a small register file, then sets the go bit. The engine reads and writes one 32-bit word at a time through a word-addressed read port and write port. When it finishes it raises a one-cycle done interrupt.

Both memory ports use valid/ready. A read request (`rd_req_valid`, `rd_addr`) is held stable until `rd_req_ready` is sampled high. The memory returns the word on `rd_rsp_valid` / `rd_rsp_data` at any later cycle, and the engine always accepts it. A write (`wr_valid`, `wr_addr`, `wr_data`) is held stable until `wr_ready` is sampled high. Either ready may stay low for any number of cycles without losing or reordering data.

Top module: `stride_copy_engine`

## Requirements
- R1: After reset, busy is 0, the control register reads 0, done_irq is 0, and neither memory port asserts valid.
- R2: Register map, by word index on the config ports:
  - 0 is the source byte address.
  - 1 is the destination byte address.
  - 2 is the total byte count.
  - 3 is the source shape and 4 is the destination shape. In both shape registers, bits 15:0 hold the run width and bits 31:16 hold the gap, each counted in 16-byte units. A shape register reads back exactly what was written.
  - 5 is control: write bit 0 = 1 to start. On read, bit 0 is go, bit 1 is busy and bit 2 is error.
- R3: Destination word k receives source word k in copy order. The amount moved between two stride events never exceeds the smallest of three values: bytes left in the source run, bytes left in the destination run, and bytes left in total.
- R4: When the source run is used up, the source pointer skips the source gap and the source run count reloads to the source width.
- R5: When the destination run is used up, the destination pointer skips the destination gap and the destination run count reloads to the destination width.
- R6: The copy ends when the remaining count reaches zero. Exactly size/4 words are written, and done_irq pulses high for exactly one cycle.
- R7: A start with a total size or a base address that is not a multiple of 4 sets the error bit. It writes nothing and gives no done pulse. The next start clears the error bit.
- R8: A start with a zero source width or a zero destination width sets the error bit, writes nothing and gives no done pulse.
- R9: The go bit clears itself when the engine finishes or rejects a start. Busy reads 1 while the engine is running. Writes to any register while busy have no effect.
- R10: Each port's valid, address and data are held stable while valid is high and ready is low. Copies under read and write back-pressure give the same result as copies without it.
- R11: A start with a total size of 0 gives one done pulse and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read word index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | High while a copy is checked or running |
| done_irq | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | 32 | Write data |

## Verification
Copies are run in several shapes, each of which separates one class of fault:
- A dense-to-dense copy isolates plain word ordering.
- A gapped source into a wider dense destination checks only the source skip and reload.
- A dense source into a narrow gapped destination, with a size that ends mid-run, checks the destination skip and the early stop on total count.
- A copy with unequal gapped runs on both sides makes the two runs end at different words, so any coupling between the two walkers shows up in the destination image.

Rejected starts are then checked: a misaligned size, a misaligned address and each zero width. A zero-size start, a single-word copy and copies under toggling ready patterns are also run. Together these cover the error path, the immediate-done path and the port hold rules.

// File: rtl/stride_copy_pkg.sv
package stride_copy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_RESP, ST_WRITE, ST_DONE
  } copy_state_e;

  localparam logic [2:0] REG_SRC       = 3'd0;
  localparam logic [2:0] REG_DST       = 3'd1;
  localparam logic [2:0] REG_SIZE      = 3'd2;
  localparam logic [2:0] REG_IN_SHAPE  = 3'd3;
  localparam logic [2:0] REG_OUT_SHAPE = 3'd4;
  localparam logic [2:0] REG_CTRL      = 3'd5;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_BUSY_BIT = 1;
  localparam int CTRL_ERR_BIT  = 2;
endpackage

// File: rtl/stride_cfg_regs.sv
module stride_cfg_regs
  import stride_copy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              clr_go,
  input  logic              set_err,
  output logic              start,
  output logic [ADDR_W+1:0] src_q,
  output logic [ADDR_W+1:0] dst_q,
  output logic [REG_W-1:0]  size_q,
  output logic [REG_W-1:0]  in_shape_q,
  output logic [REG_W-1:0]  out_shape_q
);
  localparam int BADDR_W = ADDR_W + 2;

  logic go_q, err_q;

  // A start is only recognised while the engine is idle.
  assign start = cfg_we && (cfg_waddr == REG_CTRL) && cfg_wdata[CTRL_GO_BIT] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q       <= '0;
      dst_q       <= '0;
      size_q      <= '0;
      in_shape_q  <= '0;
      out_shape_q <= '0;
      go_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (cfg_we && !busy) begin
        case (cfg_waddr)
          REG_SRC:       src_q       <= cfg_wdata[BADDR_W-1:0];
          REG_DST:       dst_q       <= cfg_wdata[BADDR_W-1:0];
          REG_SIZE:      size_q      <= cfg_wdata;
          REG_IN_SHAPE:  in_shape_q  <= cfg_wdata;
          REG_OUT_SHAPE: out_shape_q <= cfg_wdata;
          default: ;
        endcase
      end
      if (start)       go_q <= 1'b1;
      else if (clr_go) go_q <= 1'b0;
      if (start)        err_q <= 1'b0;
      else if (set_err) err_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_raddr)
      REG_SRC:       cfg_rdata = REG_W'(src_q);
      REG_DST:       cfg_rdata = REG_W'(dst_q);
      REG_SIZE:      cfg_rdata = size_q;
      REG_IN_SHAPE:  cfg_rdata = in_shape_q;
      REG_OUT_SHAPE: cfg_rdata = out_shape_q;
      REG_CTRL: begin
        cfg_rdata[CTRL_GO_BIT]   = go_q;
        cfg_rdata[CTRL_BUSY_BIT] = busy;
        cfg_rdata[CTRL_ERR_BIT]  = err_q;
      end
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stride_walker.sv
module stride_walker #(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [ADDR_W-1:0]  base_word,
  input  logic [FIELD_W-1:0] width_f,
  input  logic [FIELD_W-1:0] gap_f,
  output logic [ADDR_W-1:0]  ptr
);
  // Fields count 16-byte units; one unit is four 32-bit words.
  localparam int RUN_W = FIELD_W + 2;

  logic [RUN_W-1:0]  left_q;
  logic [RUN_W-1:0]  run_words;
  logic [ADDR_W-1:0] gap_words;

  assign run_words = {width_f, 2'b00};
  assign gap_words = ADDR_W'({gap_f, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      left_q <= '0;
    end else if (load) begin
      ptr    <= base_word;
      left_q <= run_words;
    end else if (step) begin
      if (left_q == RUN_W'(1)) begin
        ptr    <= ptr + ADDR_W'(1) + gap_words;
        left_q <= run_words;
      end else begin
        ptr    <= ptr + ADDR_W'(1);
        left_q <= left_q - RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/stride_copy_ctrl.sv
module stride_copy_ctrl
  import stride_copy_pkg::*;
#(
  parameter int CNT_W  = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bad_align,
  input  logic              zero_width,
  input  logic [CNT_W-1:0]  total_words,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              walk_load,
  output logic              walk_step,
  output logic              set_err,
  output logic              clr_go,
  output logic              busy,
  output logic              done_irq
);
  copy_state_e       st_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              rejected;

  assign rejected = bad_align || zero_width;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (start) st_q <= ST_CHECK;
        ST_CHECK: begin
          if (rejected)                 st_q <= ST_IDLE;
          else if (total_words == '0)   st_q <= ST_DONE;
          else begin
            left_q <= total_words;
            st_q   <= ST_READ;
          end
        end
        ST_READ:  if (rd_req_ready) st_q <= ST_RESP;
        ST_RESP:  if (rd_rsp_valid) begin
          data_q <= rd_rsp_data;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: if (wr_ready) begin
          left_q <= left_q - CNT_W'(1);
          st_q   <= (left_q == CNT_W'(1)) ? ST_DONE : ST_READ;
        end
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (st_q == ST_READ);
  assign wr_valid     = (st_q == ST_WRITE);
  assign wr_data      = data_q;
  assign walk_load    = (st_q == ST_CHECK) && !rejected;
  assign walk_step    = (st_q == ST_WRITE) && wr_ready;
  assign set_err      = (st_q == ST_CHECK) && rejected;
  assign clr_go       = set_err || (st_q == ST_DONE);
  assign busy         = (st_q != ST_IDLE);
  assign done_irq     = (st_q == ST_DONE);
endmodule

// File: rtl/stride_copy_engine.sv
module stride_copy_engine #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              busy,
  output logic              done_irq,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  localparam int FIELD_W = REG_W / 2;
  localparam int CNT_W   = REG_W - 2;
  localparam int DATA_W  = 32;
  localparam int NSIDE   = 2;

  logic              start, clr_go, set_err, walk_load, walk_step;
  logic [ADDR_W+1:0] src_q, dst_q;
  logic [REG_W-1:0]  size_q, in_shape_q, out_shape_q;
  logic              bad_align, zero_width;

  logic [ADDR_W-1:0]  side_base  [NSIDE];
  logic [FIELD_W-1:0] side_width [NSIDE];
  logic [FIELD_W-1:0] side_gap   [NSIDE];
  logic [ADDR_W-1:0]  side_ptr   [NSIDE];

  stride_cfg_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .busy(busy), .clr_go(clr_go), .set_err(set_err), .start(start),
    .src_q(src_q), .dst_q(dst_q), .size_q(size_q),
    .in_shape_q(in_shape_q), .out_shape_q(out_shape_q)
  );

  assign bad_align  = (size_q[1:0] != 2'b00) || (src_q[1:0] != 2'b00) ||
                      (dst_q[1:0] != 2'b00);
  assign zero_width = (in_shape_q[FIELD_W-1:0] == '0) ||
                      (out_shape_q[FIELD_W-1:0] == '0);

  assign side_base[0]  = src_q[ADDR_W+1:2];
  assign side_width[0] = in_shape_q[FIELD_W-1:0];
  assign side_gap[0]   = in_shape_q[REG_W-1:FIELD_W];
  assign side_base[1]  = dst_q[ADDR_W+1:2];
  assign side_width[1] = out_shape_q[FIELD_W-1:0];
  assign side_gap[1]   = out_shape_q[REG_W-1:FIELD_W];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    stride_walker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .load(walk_load), .step(walk_step),
      .base_word(side_base[s]), .width_f(side_width[s]), .gap_f(side_gap[s]),
      .ptr(side_ptr[s])
    );
  end

  assign rd_addr = side_ptr[0];
  assign wr_addr = side_ptr[1];

  stride_copy_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(start), .bad_align(bad_align), .zero_width(zero_width),
    .total_words(size_q[REG_W-1:2]),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .walk_load(walk_load), .walk_step(walk_step),
    .set_err(set_err), .clr_go(clr_go),
    .busy(busy), .done_irq(done_irq)
  );
endmodule

// File: rtl/stride_copy_chk.sv
module stride_copy_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_irq,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid);

  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, wr_valid, done_irq}));
endmodule

bind stride_copy_engine stride_copy_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_irq(done_irq),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_stride_copy_engine.sv
module test_stride_copy_engine;
  localparam int ADDR_W = 16;
  localparam int MEMW   = 1024;
  localparam int NV     = 10;

  // Vector table: src, dst, size (bytes), in width/gap, out width/gap (16-byte units),
  // expected error, back-pressure enable.
  localparam int V_SRC  [NV] = '{'h000, 'h100, 'h200, 'h300, 'h000, 'h000, 'h000, 'h102, 'h000, 'h040};
  localparam int V_DST  [NV] = '{'h800, 'h900, 'hA00, 'hB00, 'h800, 'h800, 'h800, 'h800, 'h800, 'hC00};
  localparam int V_SIZE [NV] = '{64, 96, 100, 120, 66, 64, 64, 64, 0, 4};
  localparam int V_IW   [NV] = '{1, 1, 3, 2, 1, 0, 1, 1, 1, 2};
  localparam int V_IG   [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0, 0};
  localparam int V_OW   [NV] = '{1, 2, 1, 3, 1, 1, 0, 1, 1, 2};
  localparam int V_OG   [NV] = '{0, 0, 2, 1, 0, 0, 1, 0, 0, 0};
  localparam bit V_ERR  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
  localparam bit V_STL  [NV] = '{0, 1, 0, 1, 0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0] cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic busy, done_irq;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [31:0] rd_rsp_data, wr_data;
  logic wr_valid, wr_ready;

  logic [31:0] mem [MEMW];
  logic [31:0] exp_mem [MEMW];
  logic [31:0] cyc = '0;
  logic init_req = 1'b0;
  logic stall_en = 1'b0;
  int seed = 1;
  int wr_count = 0;
  int done_count = 0;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  stride_copy_engine #(.ADDR_W(ADDR_W), .REG_W(32)) i_stride_copy_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .busy(busy), .done_irq(done_irq),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] init_word(input int i);
    return (32'(i) * 32'h0100_0193) ^ (32'(seed) * 32'h9E37_79B9);
  endfunction

  assign rd_req_ready = !(stall_en && cyc[0]);
  assign wr_ready     = !(stall_en && (cyc[1:0] == 2'd1));

  // Behavioural memory with one-cycle read latency.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_req) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= init_word(i);
      wr_count   <= 0;
      done_count <= 0;
    end else begin
      if (wr_valid && wr_ready) begin
        mem[wr_addr[9:0]] <= wr_data;
        wr_count <= wr_count + 1;
      end
      if (done_irq) done_count <= done_count + 1;
    end
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= mem[rd_addr[9:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic fresh_memory(input int s);
    seed = s;
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic load_case(input int c);
    cfg_write(3'd0, 32'(V_SRC[c]));
    cfg_write(3'd1, 32'(V_DST[c]));
    cfg_write(3'd2, 32'(V_SIZE[c]));
    cfg_write(3'd3, {16'(V_IG[c]), 16'(V_IW[c])});
    cfg_write(3'd4, {16'(V_OG[c]), 16'(V_OW[c])});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // Independent model: min-of-three bursts over word counts.
  task automatic build_expected(input int c);
    int rs, ri, ro, s, d, n;
    for (int i = 0; i < MEMW; i++) exp_mem[i] = init_word(i);
    if (V_ERR[c]) return;
    rs = V_SIZE[c] / 4; ri = V_IW[c] * 4; ro = V_OW[c] * 4;
    s = V_SRC[c] / 4;   d = V_DST[c] / 4;
    while (rs > 0) begin
      n = rs;
      if (ri < n) n = ri;
      if (ro < n) n = ro;
      for (int k = 0; k < n; k++) exp_mem[(d + k) % MEMW] = init_word((s + k) % MEMW);
      s += n; d += n; ri -= n; ro -= n; rs -= n;
      if (ri == 0) begin s += V_IG[c] * 4; ri = V_IW[c] * 4; end
      if (ro == 0) begin d += V_OG[c] * 4; ro = V_OW[c] * 4; end
    end
  endtask

  task automatic finish_report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    finish_report();
  end

  initial begin
    logic [31:0] rv;
    int mism, first_bad;
    string tag;

    repeat (4) @(negedge clk);
    // R1: reset state
    cfg_read(3'd5, rv);
    check(rv == 32'h0, "R1", "ctrl after reset", rv, 32'h0);
    check({busy, done_irq, rd_req_valid, wr_valid} == 4'b0, "R1", "outputs in reset",
          {busy, done_irq, rd_req_valid, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done_irq, rd_req_valid, wr_valid} == 4'b0, "R1", "outputs after reset",
          {busy, done_irq, rd_req_valid, wr_valid}, 0);

    // R2: shape register readback
    cfg_write(3'd3, 32'h0005_0003);
    cfg_read(3'd3, rv);
    check(rv == 32'h0005_0003, "R2", "source shape readback", rv, 32'h0005_0003);
    cfg_write(3'd4, 32'h0002_0007);
    cfg_read(3'd4, rv);
    check(rv == 32'h0002_0007, "R2", "destination shape readback", rv, 32'h0002_0007);

    // Vector table
    for (int c = 0; c < NV; c++) begin
      stall_en = V_STL[c];
      fresh_memory(c * 7 + 3);
      load_case(c);
      cfg_write(3'd5, 32'h1);
      wait_idle();
      build_expected(c);
      mism = 0; first_bad = 0;
      for (int i = 0; i < MEMW; i++)
        if (mem[i] !== exp_mem[i]) begin
          if (mism == 0) first_bad = i;
          mism++;
        end
      if (V_ERR[c])            tag = (V_IW[c] == 0 || V_OW[c] == 0) ? "R8" : "R7";
      else if (V_SIZE[c] == 0) tag = "R11";
      else if (V_OG[c] != 0)   tag = "R5";
      else if (V_IG[c] != 0)   tag = "R4";
      else                     tag = "R3";
      check(mism == 0, tag, $sformatf("case %0d image word %0d", c, first_bad),
            mem[first_bad], exp_mem[first_bad]);
      check(wr_count == (V_ERR[c] ? 0 : V_SIZE[c] / 4), V_ERR[c] ? tag : "R6",
            $sformatf("case %0d write count", c), wr_count, V_ERR[c] ? 0 : V_SIZE[c] / 4);
      check(done_count == (V_ERR[c] ? 0 : 1), V_ERR[c] ? tag : "R6",
            $sformatf("case %0d done pulses", c), done_count, V_ERR[c] ? 0 : 1);
      cfg_read(3'd5, rv);
      check(rv[2] == V_ERR[c], V_ERR[c] ? tag : "R7", $sformatf("case %0d error bit", c),
            rv[2], V_ERR[c]);
      check(rv[0] == 1'b0, "R9", $sformatf("case %0d go cleared", c), rv[0], 0);
      if (V_STL[c])
        check(mism == 0 && wr_count == V_SIZE[c] / 4, "R10",
              $sformatf("case %0d under back-pressure", c), wr_count, V_SIZE[c] / 4);
    end
    stall_en = 1'b0;

    // R9: busy reads 1 while running, writes during busy are ignored
    fresh_memory(50);
    load_case(0);
    cfg_write(3'd5, 32'h1);
    cfg_read(3'd5, rv);
    check(busy && rv[1], "R9", "busy while running", rv, 32'h3);
    cfg_write(3'd2, 32'd8);
    wait_idle();
    cfg_read(3'd2, rv);
    check(rv == 32'd64, "R9", "size write during busy ignored", rv, 32'd64);
    check(wr_count == 16, "R9", "words written unaffected", wr_count, 16);

    finish_report();
  end
endmodule